// File: doc/BRIEF.md
# Frequency Lock Detector with Sticky Loss Latch

This block decides whether a recovered clock runs at its nominal rate relative to a reference clock. Over a fixed window of reference cycles it counts edges of the recovered clock. It compares that count with the expected count, which is the window length times a nominal rate ratio. The error is expressed in parts per million of the expected count.

A live loss-of-lock flag rises when the error exceeds a loss threshold. It falls only when the error drops below a lower relock threshold, so an error between the two thresholds leaves the flag as it is. A sticky flag records every rising edge of the live flag. Software clears it by raising a clear control and then lowering it again. A configuration input selects whether the active-high output pin follows the live flag or the sticky flag.

The recovered-clock count crosses into the reference domain as a Gray code through a two-flop synchronizer. All decisions are made in the reference clock domain.

Top module: `freq_lock_monitor`

## Requirements
- R1: While reset is held and right after it is released, the live flag reads 1 (acquiring) and the sticky flag reads 0. Leaving this start-up state is not a loss event.
- R2: A window is 2^WIN_LOG2 reference cycles long. The live flag can change only on the reference edge that closes a window, and it stays constant at every other edge. The first decision comes at the end of the first window after reset.
- R3: If the live flag is 0 and the window error exceeds LOSS_PPM of the expected count, the live flag becomes 1. This applies to both a fast and a slow recovered clock.
- R4: If the live flag is 1 and the window error is below RELOCK_PPM of the expected count, the live flag becomes 0.
- R5: A window error between RELOCK_PPM and LOSS_PPM leaves the live flag unchanged, whatever its current value.
- R6: Every 0-to-1 transition of the live flag sets the sticky flag on the following reference cycle.
- R7: The sticky flag clears only when the clear control falls from 1 to 0. Holding the clear control at 1 does not clear it. If a new loss event arrives in the same cycle as the clear, the flag stays set.
- R8: The output pin shows the live flag when cfg_pin_static is 0 and the sticky flag when it is 1.
- R9: A recovered clock that has stopped gives a zero count and therefore sets the live flag.
- R10: The recovered-domain Gray counter changes at most one bit per recovered clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all flags are in this domain |
| clk_rec | input | 1 | Recovered clock under test |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_pin_static | input | 1 | Pin source select: 0 live flag, 1 sticky flag |
| clr_sticky | input | 1 | Sticky clear control; takes effect on its falling edge |
| lol_live | output | 1 | Live loss-of-lock status, 1 = acquiring |
| lol_sticky | output | 1 | Sticky loss-of-lock status |
| lol_pin | output | 1 | Active-high loss-of-lock output pin |

## Verification
A frequency verdict appears one reference cycle after the window's terminal count. Because a rate change usually arrives in the middle of a window, the bench holds each new rate for three full windows before it samples. At least one complete window at the new rate has then been judged. The synchronizer can make a count off by one, so every test rate sits at least one count away from a threshold. The sticky set is due one cycle after the live rise, and the clear is due one cycle after the clear control falls. The bench waits a few reference cycles before it checks these, and it always samples on the falling edge of the reference clock.

// File: rtl/fld_pkg.sv
package fld_pkg;

    function automatic logic [63:0] gray_to_bin(input logic [63:0] g, input int unsigned w);
        logic [63:0] b;
        b = '0;
        for (int i = 63; i >= 0; i--) begin
            if (i < int'(w)) begin
                if (i == int'(w) - 1) b[i] = g[i];
                else                  b[i] = b[i+1] ^ g[i];
            end
        end
        return b;
    endfunction

endpackage

// File: rtl/fld_rec_counter.sv
module fld_rec_counter #(
    parameter int CW = 20
) (
    input  logic          clk_rec,
    input  logic          rst_n,
    output logic [CW-1:0] gray_o
);
    typedef struct packed {
        logic [CW-1:0] bin;
        logic [CW-1:0] gray;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bin  = st_q.bin + 1'b1;
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk_rec or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gray_o = st_q.gray;

    // R10
    gray_step_chk: assert property (@(posedge clk_rec) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
endmodule

// File: rtl/fld_gray_sync.sv
module fld_gray_sync #(
    parameter int CW = 20
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] count_o
);
    import fld_pkg::*;

    typedef struct packed {
        logic [CW-1:0] s1;
        logic [CW-1:0] s2;
        logic [CW-1:0] bin;
    } st_t;

    st_t st_d, st_q;
    logic [63:0] conv;

    always_comb begin
        conv     = gray_to_bin(64'(st_q.s2), CW);
        st_d     = st_q;
        st_d.s1  = gray_i;
        st_d.s2  = st_q.s1;
        st_d.bin = conv[CW-1:0];
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.bin;
endmodule

// File: rtl/fld_window_judge.sv
module fld_window_judge #(
    parameter int WIN_LOG2   = 16,
    parameter int RATIO      = 1,
    parameter int LOSS_PPM   = 1000,
    parameter int RELOCK_PPM = 250,
    parameter int CW         = 20
) (
    input  logic          clk_ref,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    output logic          lol_o
);
    localparam logic [63:0] EXP_CNT    = (64'd1 << WIN_LOG2) * 64'(RATIO);
    localparam logic [63:0] LOSS_LIM   = 64'(LOSS_PPM) * EXP_CNT;
    localparam logic [63:0] RELOCK_LIM = 64'(RELOCK_PPM) * EXP_CNT;
    localparam logic [63:0] PPM_SCALE  = 64'd1_000_000;

    typedef struct packed {
        logic [WIN_LOG2-1:0] wcnt;
        logic [CW-1:0]       prev;
        logic                lol;
    } st_t;

    st_t st_d, st_q;
    logic              win_end;
    logic [CW-1:0]     delta;
    logic [CW-1:0]     err_raw;
    logic [CW-1:0]     err_abs;
    logic [63:0]       err_scaled;

    always_comb begin
        win_end    = (st_q.wcnt == '1);
        delta      = count_i - st_q.prev;
        err_raw    = delta - EXP_CNT[CW-1:0];
        err_abs    = err_raw[CW-1] ? (~err_raw + 1'b1) : err_raw;
        err_scaled = 64'(err_abs) * PPM_SCALE;

        st_d      = st_q;
        st_d.wcnt = st_q.wcnt + 1'b1;
        if (win_end) begin
            st_d.prev = count_i;
            if (st_q.lol) begin
                if (err_scaled < RELOCK_LIM) st_d.lol = 1'b0;
            end else begin
                if (err_scaled > LOSS_LIM) st_d.lol = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lol  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lol_o = st_q.lol;

    // R2
    window_only_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (st_q.wcnt != '1) |=> $stable(st_q.lol));

    // R5
    band_hold_lo_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (win_end && !st_q.lol && err_scaled <= LOSS_LIM) |=> !lol_o);

    // R5
    band_hold_hi_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (win_end && st_q.lol && err_scaled >= RELOCK_LIM) |=> lol_o);

    initial begin
        relock_order_chk: assert (RELOCK_PPM < LOSS_PPM);
    end
endmodule

// File: rtl/fld_sticky_latch.sv
module fld_sticky_latch (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic lol_i,
    input  logic clr_i,
    input  logic cfg_static_i,
    output logic sticky_o,
    output logic pin_o
);
    typedef struct packed {
        logic sticky;
        logic clr_prev;
        logic lol_prev;
    } st_t;

    st_t  st_d, st_q;
    logic lol_rise;
    logic clr_done;

    always_comb begin
        lol_rise = lol_i && !st_q.lol_prev;
        clr_done = st_q.clr_prev && !clr_i;
        st_d          = st_q;
        st_d.lol_prev = lol_i;
        st_d.clr_prev = clr_i;
        if (lol_rise)      st_d.sticky = 1'b1;
        else if (clr_done) st_d.sticky = 1'b0;
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.lol_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sticky_o = st_q.sticky;
    assign pin_o    = cfg_static_i ? st_q.sticky : lol_i;

    // R6
    rise_sets_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (lol_i && !st_q.lol_prev) |=> sticky_o);

    // R7
    sticky_keep_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (sticky_o && !(st_q.clr_prev && !clr_i)) |=> sticky_o);
endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor #(
    parameter int WIN_LOG2   = 16,
    parameter int RATIO      = 1,
    parameter int LOSS_PPM   = 1000,
    parameter int RELOCK_PPM = 250
) (
    input  logic clk_ref,
    input  logic clk_rec,
    input  logic rst_n,
    input  logic cfg_pin_static,
    input  logic clr_sticky,
    output logic lol_live,
    output logic lol_sticky,
    output logic lol_pin
);
    localparam int CW = WIN_LOG2 + $clog2(RATIO + 1) + 3;

    logic [CW-1:0] rec_gray;
    logic [CW-1:0] rec_count;

    fld_rec_counter #(.CW(CW)) u_cnt (
        .clk_rec (clk_rec),
        .rst_n   (rst_n),
        .gray_o  (rec_gray)
    );

    fld_gray_sync #(.CW(CW)) u_sync (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .gray_i  (rec_gray),
        .count_o (rec_count)
    );

    fld_window_judge #(
        .WIN_LOG2   (WIN_LOG2),
        .RATIO      (RATIO),
        .LOSS_PPM   (LOSS_PPM),
        .RELOCK_PPM (RELOCK_PPM),
        .CW         (CW)
    ) u_judge (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .count_i (rec_count),
        .lol_o   (lol_live)
    );

    fld_sticky_latch u_latch (
        .clk_ref      (clk_ref),
        .rst_n        (rst_n),
        .lol_i        (lol_live),
        .clr_i        (clr_sticky),
        .cfg_static_i (cfg_pin_static),
        .sticky_o     (lol_sticky),
        .pin_o        (lol_pin)
    );

    // R8
    pin_static_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cfg_pin_static |-> (lol_pin == lol_sticky));
endmodule

// File: tb/freq_lock_monitor_bench.sv
`timescale 1ns/1ps
module freq_lock_monitor_bench;
    localparam int WL   = 10;
    localparam int NOM  = 1 << WL;
    localparam int LOSS = 20000;
    localparam int RELK = 5000;

    logic clk_ref = 1'b0;
    logic clk_rec = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_pin_static = 1'b0;
    logic clr_sticky = 1'b0;
    logic lol_live, lol_sticky, lol_pin;

    real rec_half = 5.0;
    bit  rec_run  = 1'b1;
    int  total = 0;
    int  bad   = 0;
    bit  exp_lol;

    freq_lock_monitor #(.WIN_LOG2(WL), .RATIO(1), .LOSS_PPM(LOSS), .RELOCK_PPM(RELK)) u_freq_lock_monitor (
        .clk_ref(clk_ref), .clk_rec(clk_rec), .rst_n(rst_n),
        .cfg_pin_static(cfg_pin_static), .clr_sticky(clr_sticky),
        .lol_live(lol_live), .lol_sticky(lol_sticky), .lol_pin(lol_pin)
    );

    always #5 clk_ref = ~clk_ref;

    always begin
        if (rec_run) begin
            #(rec_half) clk_rec = ~clk_rec;
        end else begin
            #1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_rate(input int d);
        rec_half = 5.0 * real'(NOM) / real'(NOM + d);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk_ref);
        @(negedge clk_ref);
    endtask

    task automatic settle();
        cycles(3 * NOM + 8);
    endtask

    initial begin
        #1_900_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        set_rate(0);
        cycles(4);
        // R1 during reset
        check("R1 live in reset", lol_live, 1);
        check("R1 sticky in reset", lol_sticky, 0);
        rst_n = 1'b1;
        cycles(2);
        check("R1 pin live after reset", lol_pin, 1);
        cfg_pin_static = 1'b1;
        cycles(1);
        check("R8 pin static after reset", lol_pin, 0);
        cfg_pin_static = 1'b0;
        cycles(NOM - 20);
        // R2 no decision before first window ends
        check("R2 live before first window", lol_live, 1);
        cycles(40);
        check("R2 R4 relock after first window", lol_live, 0);
        check("R1 startup is no event", lol_sticky, 0);

        set_rate(10); settle();
        check("R5 hold locked in band", lol_live, 0);

        set_rate(36); settle();
        check("R3 fast loss", lol_live, 1);
        check("R6 sticky set", lol_sticky, 1);
        cfg_pin_static = 1'b1; cycles(1);
        check("R8 pin static high", lol_pin, 1);

        set_rate(10); settle();
        check("R5 hold lost in band", lol_live, 1);

        set_rate(2); settle();
        check("R4 relock", lol_live, 0);
        check("R7 sticky survives relock", lol_sticky, 1);
        check("R8 pin static shows sticky", lol_pin, 1);
        cfg_pin_static = 1'b0; cycles(1);
        check("R8 pin live shows live", lol_pin, 0);

        clr_sticky = 1'b1; cycles(5);
        check("R7 clear held high no effect", lol_sticky, 1);
        clr_sticky = 1'b0; cycles(3);
        check("R7 cleared after fall", lol_sticky, 0);

        set_rate(-34); settle();
        check("R3 slow loss", lol_live, 1);
        check("R6 sticky set again", lol_sticky, 1);

        set_rate(0); settle();
        check("R4 relock nominal", lol_live, 0);
        rec_run = 1'b0; settle();
        check("R9 stopped clock loss", lol_live, 1);
        rec_run = 1'b1;

        // R3 R4 R5 sweep against a hysteresis model
        exp_lol = 1'b1;
        for (int d = -32; d <= 32; d += 8) begin
            int mag;
            mag = (d < 0) ? -d : d;
            set_rate(d); settle();
            if (mag >= 21) exp_lol = 1'b1;
            else if (mag <= 5) exp_lol = 1'b0;
            check($sformatf("R3 R4 R5 sweep d=%0d", d), lol_live, int'(exp_lol));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule